// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the fixed fields of a 32-bit base-integer instruction into the control word of a single-cycle datapath. It reads the 7-bit major opcode, the 3-bit minor function field, instruction bit 30 and the comparator's branch verdict. From these it produces the immediate format, the second-operand source, the ALU operation, the data-memory and register-file write enables, the write-back source, the destination-register source and the next-PC source. Every output is a pure function of the present inputs, because the PC, the register file and the data memory all take their new values on the same rising edge that closes the instruction.

Supported classes are register-register ALU, register-immediate ALU, word load, word store, the six conditional branches, the direct jump-and-link and the register-indirect jump-and-link. The ALU operation comes from one of three paths. It is taken from the instruction fields for ALU classes, from the opcode for branches (a compare subtraction), and is a forced add for address and link arithmetic. Anything outside the supported set is reported as illegal and leaves all state untouched.

Top module: `ctl_hardwired_decoder`

## Requirements
- R1: Opcode 0110011 (register-register) gives op2_imm=0, rf_we=1, mem_we=0, wb_src=0 (ALU), pc_src=0 (sequential), illegal=0. alu_fn follows funct3: 000 add(0) or, with bit30 set, sub(1); 001 sll(2); 010 slt(3); 011 sltu(4); 100 xor(5); 101 srl(6) or, with bit30 set, sra(7); 110 or(8); 111 and(9).
- R2: Opcode 0010011 (register-immediate) gives imm_kind=0 (I), op2_imm=1, rf_we=1, mem_we=0, wb_src=0, pc_src=0. alu_fn uses the R1 funct3 map, with bit30 honoured only for funct3=101 (sra). With funct3=000, bit30 is ignored and the result is add.
- R3: Opcode 0000011 with funct3=010 gives imm_kind=0, op2_imm=1, alu_fn=add, rf_we=1, mem_we=0, wb_src=1 (memory), pc_src=0.
- R4: Opcode 0100011 with funct3=010 gives imm_kind=1 (S), op2_imm=1, alu_fn=add, mem_we=1, rf_we=0, pc_src=0.
- R5: Opcode 1100011 with funct3 in {000,001,100,101,110,111} gives imm_kind=2 (SB), alu_fn=sub, rf_we=0, mem_we=0. pc_src is 1 (branch target) when br_taken=1 and 0 otherwise.
- R6: Opcode 1101111 gives imm_kind=4 (J), pc_src=3 (absolute jump), rf_we=1, mem_we=0, wb_src=2 (PC+4), link_x1=1. funct3 and bit30 are ignored.
- R7: Opcode 1100111 with funct3=000 gives imm_kind=0, op2_imm=1, alu_fn=add, pc_src=2 (register-indirect), rf_we=1, mem_we=0, wb_src=2, link_x1=0.
- R8: Any opcode not listed in R1 to R7 gives illegal=1, rf_we=0, mem_we=0, pc_src=0. Every supported instruction gives illegal=0.
- R9: A branch with funct3 010 or 011, or a register-indirect jump with funct3 other than 000, is treated as in R8.
- R10: With WORD_ONLY=1, a load or store whose funct3 is not 010 is treated as in R8. With WORD_ONLY=0, such a load or store decodes as in R3 or R4.
- R11: mem_we and rf_we are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode, instruction bits 6:0 |
| funct3 | input | 3 | Minor function, instruction bits 14:12 |
| funct7_b30 | input | 1 | Instruction bit 30 |
| br_taken | input | 1 | Branch comparator verdict for the current instruction |
| imm_kind | output | 3 | Immediate format: 0 I, 1 S, 2 SB, 3 U, 4 J |
| op2_imm | output | 1 | Second ALU operand: 1 immediate, 0 register |
| alu_fn | output | 4 | ALU operation code (see R1) |
| mem_we | output | 1 | Data-memory write enable |
| rf_we | output | 1 | Register-file write enable |
| wb_src | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| link_x1 | output | 1 | Destination register: 1 forces x1, 0 uses rd |
| pc_src | output | 2 | Next PC: 0 PC+4, 1 branch, 2 register-indirect, 3 absolute jump |
| illegal | output | 1 | Instruction is outside the supported set |

## Verification
The bench builds two copies side by side on the same inputs. One uses the default WORD_ONLY=1 and the other uses WORD_ONLY=0. With both copies, one load or store with a byte or halfword width shows the strict build rejecting it and the lenient build decoding it as an ordinary memory access. All other scenarios are checked on the strict copy. Those scenarios sweep every funct3 value with both settings of bit 30 for both ALU classes, and every branch code with the verdict both taken and not taken. They also cover jumps with stray function bits and a spread of unsupported opcodes.

// File: rtl/ctl_dec_pkg.sv
// Package: shared encodings for the single-cycle control decoder.
// Assumes the 32-bit base integer instruction layout.
package ctl_dec_pkg;

    localparam int OPC_W = 7;
    localparam int F3_W  = 3;
    localparam int FN_W  = 4;
    localparam int IK_W  = 3;
    localparam int WB_W  = 2;
    localparam int PC_W  = 2;

    localparam logic [OPC_W-1:0] OPC_ALU_RR = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_ALU_RI = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

    localparam logic [F3_W-1:0] F3_WORD = 3'b010;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 4'd0, FN_SUB = 4'd1, FN_SLL = 4'd2, FN_SLT = 4'd3,
        FN_SLTU = 4'd4, FN_XOR = 4'd5, FN_SRL = 4'd6, FN_SRA = 4'd7,
        FN_OR = 4'd8, FN_AND = 4'd9
    } alu_fn_e;

    typedef enum logic [IK_W-1:0] {
        IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
    } imm_kind_e;

    typedef enum logic [WB_W-1:0] {
        WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC = 2'd2
    } wb_src_e;

    typedef enum logic [PC_W-1:0] {
        PC_SEQ = 2'd0, PC_BR = 2'd1, PC_RIND = 2'd2, PC_JABS = 2'd3
    } pc_src_e;

    typedef enum logic [2:0] {
        CL_ALU_RR, CL_ALU_RI, CL_LOAD, CL_STORE,
        CL_BRANCH, CL_JAL, CL_JALR, CL_NONE
    } iclass_e;

endpackage

// File: rtl/ctl_opclass.sv
// Module: sorts an instruction into a supported class, or CL_NONE.
// Assumes: funct3 qualifies loads/stores (width), branches and the
// indirect jump; WORD_ONLY restricts memory accesses to full words.
module ctl_opclass
    import ctl_dec_pkg::*;
#(
    parameter bit WORD_ONLY = 1'b1
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [F3_W-1:0]  funct3,
    output iclass_e          cls
);

    logic width_ok;
    logic br_code_ok;

    // Width qualifier for memory accesses, chosen by the build variant.
    generate
        if (WORD_ONLY) begin : g_word_only
            assign width_ok = (funct3 == F3_WORD);
        end else begin : g_any_width
            assign width_ok = 1'b1;
        end
    endgenerate

    // Branch codes 010 and 011 have no compare defined.
    assign br_code_ok = (funct3[2:1] != 2'b01);

    // Opcode to class, with the funct3 qualifiers applied.
    always_comb begin
        case (opcode)
            OPC_ALU_RR: cls = CL_ALU_RR;
            OPC_ALU_RI: cls = CL_ALU_RI;
            OPC_LOAD:   cls = width_ok ? CL_LOAD : CL_NONE;
            OPC_STORE:  cls = width_ok ? CL_STORE : CL_NONE;
            OPC_BRANCH: cls = br_code_ok ? CL_BRANCH : CL_NONE;
            OPC_JAL:    cls = CL_JAL;
            OPC_JALR:   cls = (funct3 == '0) ? CL_JALR : CL_NONE;
            default:    cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/ctl_alufn.sv
// Module: ALU operation select over three paths: instruction fields
// (ALU classes), opcode-derived (branch compare), forced add (others).
// Assumes bit 30 is meaningful only for sub and arithmetic shift.
module ctl_alufn
    import ctl_dec_pkg::*;
(
    input  iclass_e         cls,
    input  logic [F3_W-1:0] funct3,
    input  logic            funct7_b30,
    output alu_fn_e         fn
);

    alu_fn_e fn_field;
    alu_fn_e fn_opc;
    logic    sub_ok;

    // Only the register-register form may turn add into sub.
    assign sub_ok = (cls == CL_ALU_RR) && funct7_b30;

    // Field path: funct3 plus bit 30.
    always_comb begin
        case (funct3)
            3'b000:  fn_field = sub_ok ? FN_SUB : FN_ADD;
            3'b001:  fn_field = FN_SLL;
            3'b010:  fn_field = FN_SLT;
            3'b011:  fn_field = FN_SLTU;
            3'b100:  fn_field = FN_XOR;
            3'b101:  fn_field = funct7_b30 ? FN_SRA : FN_SRL;
            3'b110:  fn_field = FN_OR;
            default: fn_field = FN_AND;
        endcase
    end

    // Opcode path: branches compare by subtraction.
    assign fn_opc = (cls == CL_BRANCH) ? FN_SUB : FN_ADD;

    // Path select by class; every other class gets the forced add.
    always_comb begin
        case (cls)
            CL_ALU_RR, CL_ALU_RI: fn = fn_field;
            CL_BRANCH:            fn = fn_opc;
            default:              fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/ctl_hardwired_decoder.sv
// Module: top of the single-cycle control decoder. Fully combinational,
// since all architectural state updates on the edge ending the cycle.
// Assumes br_taken is already resolved for the current instruction.
module ctl_hardwired_decoder
    import ctl_dec_pkg::*;
#(
    parameter bit WORD_ONLY = 1'b1
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [F3_W-1:0]  funct3,
    input  logic             funct7_b30,
    input  logic             br_taken,
    output logic [IK_W-1:0]  imm_kind,
    output logic             op2_imm,
    output logic [FN_W-1:0]  alu_fn,
    output logic             mem_we,
    output logic             rf_we,
    output logic [WB_W-1:0]  wb_src,
    output logic             link_x1,
    output logic [PC_W-1:0]  pc_src,
    output logic             illegal
);

    iclass_e   cls;
    alu_fn_e   fn;
    imm_kind_e ik;
    wb_src_e   wb;
    pc_src_e   pcs;

    ctl_opclass #(.WORD_ONLY(WORD_ONLY)) u_opclass (
        .opcode (opcode),
        .funct3 (funct3),
        .cls    (cls)
    );

    ctl_alufn u_alufn (
        .cls        (cls),
        .funct3     (funct3),
        .funct7_b30 (funct7_b30),
        .fn         (fn)
    );

    // Control table: one row per class; defaults form the safe no-op row.
    always_comb begin
        ik      = IMM_I;
        op2_imm = 1'b0;
        mem_we  = 1'b0;
        rf_we   = 1'b0;
        wb      = WB_ALU;
        link_x1 = 1'b0;
        pcs     = PC_SEQ;
        illegal = 1'b0;
        case (cls)
            CL_ALU_RR: begin
                rf_we = 1'b1;
            end
            CL_ALU_RI: begin
                op2_imm = 1'b1;
                rf_we   = 1'b1;
            end
            CL_LOAD: begin
                op2_imm = 1'b1;
                rf_we   = 1'b1;
                wb      = WB_MEM;
            end
            CL_STORE: begin
                ik      = IMM_S;
                op2_imm = 1'b1;
                mem_we  = 1'b1;
            end
            CL_BRANCH: begin
                ik  = IMM_B;
                pcs = br_taken ? PC_BR : PC_SEQ;
            end
            CL_JAL: begin
                ik      = IMM_J;
                rf_we   = 1'b1;
                wb      = WB_PC;
                link_x1 = 1'b1;
                pcs     = PC_JABS;
            end
            CL_JALR: begin
                op2_imm = 1'b1;
                rf_we   = 1'b1;
                wb      = WB_PC;
                pcs     = PC_RIND;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end

    assign imm_kind = ik;
    assign alu_fn   = fn;
    assign wb_src   = wb;
    assign pc_src   = pcs;

endmodule

// File: rtl/ctl_decoder_chk.sv
// Module: property checker bound to the decoder. Relations between
// control outputs that any legal decode must respect.
module ctl_decoder_chk (
    input logic [6:0] opcode,
    input logic [2:0] funct3,
    input logic       funct7_b30,
    input logic       br_taken,
    input logic [2:0] imm_kind,
    input logic       op2_imm,
    input logic [3:0] alu_fn,
    input logic       mem_we,
    input logic       rf_we,
    input logic [1:0] wb_src,
    input logic       link_x1,
    input logic [1:0] pc_src,
    input logic       illegal
);

    // Immediate checks on the settled control word.
    always_comb begin
        p_illegal_quiet_r8: assert (!illegal || (!rf_we && !mem_we && pc_src == 2'd0));
        p_no_dual_write_r11: assert (!(mem_we && rf_we));
        p_store_form_r4: assert (!mem_we || (imm_kind == 3'd1 && op2_imm && alu_fn == 4'd0));
        p_mem_wb_r3: assert (wb_src != 2'd1 || (rf_we && op2_imm && alu_fn == 4'd0 && pc_src == 2'd0));
        p_branch_taken_r5: assert (pc_src != 2'd1 || (br_taken && !rf_we && !mem_we && imm_kind == 3'd2));
        p_link_pc_r6: assert (wb_src != 2'd2 || (rf_we && pc_src[1]));
        p_x1_only_jabs_r6: assert (!link_x1 || pc_src == 2'd3);
        p_rind_form_r7: assert (pc_src != 2'd2 || (opcode == 7'b1100111 && funct3 == 3'b000 && op2_imm));
        p_sub_needs_b30_r1: assert (alu_fn != 4'd1 || funct7_b30 || opcode == 7'b1100011);
    end

endmodule

bind ctl_hardwired_decoder ctl_decoder_chk u_chk (.*);

// File: tb/tb_ctl_hardwired_decoder.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_ctl_hardwired_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int DC = -1;   // field not compared

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [6:0] opcode = '0;
    logic [2:0] funct3 = '0;
    logic       funct7_b30 = 1'b0;
    logic       br_taken = 1'b0;

    logic [2:0] imm_kind, l_imm_kind;
    logic       op2_imm, l_op2_imm;
    logic [3:0] alu_fn, l_alu_fn;
    logic       mem_we, l_mem_we, rf_we, l_rf_we;
    logic [1:0] wb_src, l_wb_src;
    logic       link_x1, l_link_x1;
    logic [1:0] pc_src, l_pc_src;
    logic       illegal, l_illegal;

    int n_checks = 0;
    int n_errors = 0;

    ctl_hardwired_decoder #(.WORD_ONLY(1'b1)) dut (
        .opcode(opcode), .funct3(funct3), .funct7_b30(funct7_b30), .br_taken(br_taken),
        .imm_kind(imm_kind), .op2_imm(op2_imm), .alu_fn(alu_fn), .mem_we(mem_we),
        .rf_we(rf_we), .wb_src(wb_src), .link_x1(link_x1), .pc_src(pc_src), .illegal(illegal)
    );

    ctl_hardwired_decoder #(.WORD_ONLY(1'b0)) dut_lax (
        .opcode(opcode), .funct3(funct3), .funct7_b30(funct7_b30), .br_taken(br_taken),
        .imm_kind(l_imm_kind), .op2_imm(l_op2_imm), .alu_fn(l_alu_fn), .mem_we(l_mem_we),
        .rf_we(l_rf_we), .wb_src(l_wb_src), .link_x1(l_link_x1), .pc_src(l_pc_src), .illegal(l_illegal)
    );

    // Compare one field unless it is a don't-care.
    task automatic chk(input string req, input string fld, input int act, input int exp);
        if (exp == DC) return;
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s op=%b f3=%b b30=%b tk=%b actual=%0d expected=%0d",
                     req, fld, opcode, funct3, funct7_b30, br_taken, act, exp);
        end
    endtask

    // Drive an instruction on the falling edge, let it settle.
    task automatic drive(input logic [6:0] op, input logic [2:0] f3, input logic b, input logic tk);
        @(negedge clk);
        opcode = op; funct3 = f3; funct7_b30 = b; br_taken = tk;
        #1;
    endtask

    // Whole control word of the strict copy against expectations.
    task automatic expect_word(input string req, input int ik, input int o2, input int fn,
                               input int mw, input int rw, input int wb, input int lk,
                               input int pc, input int il);
        chk(req, "imm_kind", int'(imm_kind), ik);
        chk(req, "op2_imm",  int'(op2_imm), o2);
        chk(req, "alu_fn",   int'(alu_fn), fn);
        chk(req, "mem_we",   int'(mem_we), mw);
        chk(req, "rf_we",    int'(rf_we), rw);
        chk(req, "wb_src",   int'(wb_src), wb);
        chk(req, "link_x1",  int'(link_x1), lk);
        chk(req, "pc_src",   int'(pc_src), pc);
        chk(req, "illegal",  int'(illegal), il);
    endtask

    // Expected ALU code from the funct3 map in R1.
    function automatic int fn_of(input logic [2:0] f3, input logic b, input bit allow_sub);
        int base;
        case (f3)
            3'd0: base = (allow_sub && b) ? 1 : 0;
            3'd1: base = 2;
            3'd2: base = 3;
            3'd3: base = 4;
            3'd4: base = 5;
            3'd5: base = b ? 7 : 6;
            3'd6: base = 8;
            default: base = 9;
        endcase
        return base;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        drive(7'd0, 3'd0, 1'b0, 1'b0);
        expect_word("R8", DC, DC, DC, 0, 0, DC, DC, 0, 1);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_alu_rr();
        for (int f = 0; f < 8; f++)
            for (int b = 0; b < 2; b++) begin
                drive(7'b0110011, 3'(f), 1'(b), 1'b1);
                expect_word("R1", DC, 0, fn_of(3'(f), 1'(b), 1'b1), 0, 1, 0, 0, 0, 0);
            end
    endtask

    task automatic t_alu_ri();
        for (int f = 0; f < 8; f++)
            for (int b = 0; b < 2; b++) begin
                drive(7'b0010011, 3'(f), 1'(b), 1'b1);
                expect_word("R2", 0, 1, fn_of(3'(f), 1'(b), 1'b0), 0, 1, 0, 0, 0, 0);
            end
    endtask

    task automatic t_load();
        drive(7'b0000011, 3'b010, 1'b1, 1'b1);
        expect_word("R3", 0, 1, 0, 0, 1, 1, 0, 0, 0);
    endtask

    task automatic t_store();
        drive(7'b0100011, 3'b010, 1'b1, 1'b1);
        expect_word("R4", 1, 1, 0, 1, 0, DC, DC, 0, 0);
        chk("R11", "mem_we&rf_we", int'(mem_we & rf_we), 0);
    endtask

    task automatic t_branch();
        for (int f = 0; f < 8; f++)
            for (int t = 0; t < 2; t++) begin
                drive(7'b1100011, 3'(f), 1'b0, 1'(t));
                if (f == 2 || f == 3)
                    expect_word("R9", DC, DC, DC, 0, 0, DC, DC, 0, 1);
                else
                    expect_word("R5", 2, DC, 1, 0, 0, DC, DC, t, 0);
            end
    endtask

    task automatic t_jal();
        drive(7'b1101111, 3'b011, 1'b1, 1'b0);
        expect_word("R6", 4, DC, DC, 0, 1, 2, 1, 3, 0);
        drive(7'b1101111, 3'b000, 1'b0, 1'b1);
        expect_word("R6", 4, DC, DC, 0, 1, 2, 1, 3, 0);
    endtask

    task automatic t_jalr();
        drive(7'b1100111, 3'b000, 1'b0, 1'b1);
        expect_word("R7", 0, 1, 0, 0, 1, 2, 0, 2, 0);
        drive(7'b1100111, 3'b001, 1'b0, 1'b0);
        expect_word("R9", DC, DC, DC, 0, 0, DC, DC, 0, 1);
    endtask

    task automatic t_unknown();
        logic [6:0] ops [5] = '{7'b0110111, 7'b0000000, 7'b1111111, 7'b0001111, 7'b1110011};
        foreach (ops[i]) begin
            drive(ops[i], 3'b010, 1'b1, 1'b1);
            expect_word("R8", DC, DC, DC, 0, 0, DC, DC, 0, 1);
        end
    endtask

    task automatic t_width();
        drive(7'b0000011, 3'b000, 1'b0, 1'b0);
        expect_word("R10", DC, DC, DC, 0, 0, DC, DC, 0, 1);
        chk("R10", "lax.illegal", int'(l_illegal), 0);
        chk("R10", "lax.rf_we",   int'(l_rf_we), 1);
        chk("R10", "lax.wb_src",  int'(l_wb_src), 1);
        drive(7'b0100011, 3'b001, 1'b0, 1'b0);
        expect_word("R10", DC, DC, DC, 0, 0, DC, DC, 0, 1);
        chk("R10", "lax.mem_we",   int'(l_mem_we), 1);
        chk("R10", "lax.imm_kind", int'(l_imm_kind), 1);
        chk("R10", "lax.rf_we",    int'(l_rf_we), 0);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_alu_rr();
        t_alu_ri();
        t_load();
        t_store();
        t_branch();
        t_jal();
        t_jalr();
        t_unknown();
        t_width();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule